// File: doc/BRIEF.md
# Parity-Encoded Debug Enable Bank

This block holds the enable state for a set of debug controls, grouped in 32-bit words and reached through a single-cycle register port. In the default parity encoding each control owns two adjacent bits. The even bit of the pair means "this control is on" and the odd bit means "this control is forced off". A design built without parity treats every bit as a plain enable and has no forced-off bits.

Software writes enable words, and the bank screens each write against a permission mask that arrives as an input. A write that would raise any bit the mask does not allow is refused as a whole. Per-bit lock registers freeze individual enable bits. Both refusals and lock hits set sticky flags.

When secure provisioning starts, a single pulse on `apply_sp_mask` filters every enable word through the provisioning mask in the same clock edge. Where a control loses its enable and the mask marks that control for disabling, the filter sets the paired forced-off bit.

Top module: `dbg_pair_bank`

## Requirements
- R1: After synchronous reset every enable bit, every lock bit and both flags are zero, so in parity mode no control has either bit of its pair set.
- R2: Byte addresses 0x100+4i hold enable word i, 0x110+4i lock word i, 0x120+4i provisioning mask word i and 0x130+4i permission mask word i, for i in 0..3. Reads return the addressed word in the same cycle. Reads of any other address, including misaligned ones, return zero.
- R3: A write to an enable word whose set bits all lie inside that word's permission mask, and which touches no locked bit, reads back exactly the written value after the clock edge. The same value appears on `dbg_enable_o` bits 32i+31..32i.
- R4: A write to an enable word that has any set bit outside that word's permission mask leaves the whole word unchanged and sets `mism_flag_o`, which stays set until reset.
- R5: Lock bits are set-only. Each 1 written to a lock word sets that bit, and writing 0 to a lock bit has no effect.
- R6: An enable write leaves every locked bit at its old value and updates the unlocked bits. If it tries to change a locked bit, `lock_flag_o` is set and stays set until reset.
- R7: Writes to the provisioning mask and permission mask addresses have no effect. Those words always read back the input masks.
- R8: One clock after an `apply_sp_mask` pulse, an enable-position bit (even bits in parity mode) keeps its old value only where the provisioning mask bit at that position is 1. Otherwise it is 0.
- R9: In parity mode, after the pulse the odd bit 2k+1 is 1 exactly when the new bit 2k is 0 and provisioning mask bit 2k+1 is 1. Earlier odd-bit values are discarded.
- R10: The masking pulse takes priority. It ignores lock bits, an enable write in the same cycle is dropped without setting either flag, and a lock write in the same cycle still takes effect.
- R11: With PARITY=0 all 32 bits of a word are enable bits, and the pulse leaves each word equal to the old value ANDed with the provisioning mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_wr | input | 1 | Write strobe, one cycle per write |
| req_addr | input | AW (12) | Byte address |
| req_wdata | input | DW (32) | Write data |
| rd_data | output | DW (32) | Read data for req_addr, combinational |
| apply_sp_mask | input | 1 | One-cycle pulse that applies the provisioning mask |
| sp_dis_mask_i | input | NW*DW (128) | Provisioning mask, word i at bits 32i+31..32i |
| dis_mask_i | input | NW*DW (128) | Permission mask for enable writes |
| dbg_enable_o | output | NW*DW (128) | Current enable/disable pair state |
| mism_flag_o | output | 1 | Sticky: an enable write was refused by the permission mask |
| lock_flag_o | output | 1 | Sticky: an enable write tried to change a locked bit |

## Verification
The bench runs a parity build and a non-parity build side by side on the same stimulus. It walks a single one through every bit, sweeps eight provisioning-mask patterns through the masking pulse, and probes the ends of the address map and misaligned addresses. Several faults would be exposed this way:
- A wrong shift direction, or keeping stale odd bits, gives disable bits in the wrong pair.
- A partial refusal lets permitted bits of a refused word through.
- Lock bits that honour the masking pulse leave locked enables standing after provisioning.
- A same-cycle write that wins over the pulse shows up in the readback or as a spurious flag.

// File: rtl/dpb_pkg.sv
// Shared types for the debug pair bank.
// Assumes: register windows are word-aligned and laid out back to back.
package dpb_pkg;
    typedef enum logic [2:0] {
        RG_EN   = 3'd0,
        RG_LOCK = 3'd1,
        RG_SPM  = 3'd2,
        RG_DM   = 3'd3,
        RG_NONE = 3'd4
    } dpb_region_e;
endpackage

// File: rtl/dpb_decode.sv
// Address decoder: maps a byte address onto one of four windows and a word index.
// Assumes: the windows start at BASE, each is NW words long, and misaligned addresses match nothing.
module dpb_decode
    import dpb_pkg::*;
#(
    parameter int AW   = 12,
    parameter int NW   = 4,
    parameter int BASE = 'h100
) (
    input  logic [AW-1:0]         addr,
    output dpb_region_e           region,
    output logic [$clog2(NW)-1:0] idx
);
    localparam int IW        = $clog2(NW);
    localparam int WIN_BYTES = NW * 4;
    localparam int SPAN      = 4 * WIN_BYTES;

    int unsigned off;
    int unsigned win;

    // Split the offset from BASE into a window number and a word index.
    always_comb begin
        off    = 32'(addr) - 32'(BASE);
        win    = off / WIN_BYTES;
        idx    = IW'((off % WIN_BYTES) >> 2);
        region = RG_NONE;
        if (32'(addr) >= 32'(BASE) && off < SPAN && addr[1:0] == 2'b00) begin
            case (win)
                0:       region = RG_EN;
                1:       region = RG_LOCK;
                2:       region = RG_SPM;
                default: region = RG_DM;
            endcase
        end
    end
endmodule

// File: rtl/dpb_word.sv
// One enable word with its lock word. Screens writes, holds locked bits, applies the provisioning filter.
// Assumes: at most one of wr_sel and apply is high (the top gates writes during apply).
module dpb_word #(
    parameter int DW     = 32,
    parameter bit PARITY = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_sel,
    input  logic          lk_sel,
    input  logic          apply,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] spm,
    input  logic [DW-1:0] dm,
    output logic [DW-1:0] en_q,
    output logic [DW-1:0] lk_q,
    output logic          mism_hit,
    output logic          lock_hit
);
    localparam logic [DW-1:0] EN_POS  = PARITY ? {(DW/2){2'b01}} : {DW{1'b1}};
    localparam logic [DW-1:0] DIS_POS = PARITY ? {(DW/2){2'b10}} : {DW{1'b0}};

    logic [DW-1:0] kept;
    logic [DW-1:0] filtered;
    logic [DW-1:0] en_d;

    // Classify the write: refused by the permission mask, or touching a locked bit.
    always_comb begin
        mism_hit = wr_sel && (|(wdata & ~dm));
        lock_hit = wr_sel && !mism_hit && (|((wdata ^ en_q) & lk_q));
    end

    // Provisioning filter: keep permitted enables, raise disables for controls that lost them.
    always_comb begin
        kept     = en_q & spm & EN_POS;
        filtered = kept | (((~kept & EN_POS) << 1) & spm & DIS_POS);
    end

    // Next enable value: the filter wins, then an accepted write merged around the locks.
    always_comb begin
        en_d = en_q;
        if (apply) begin
            en_d = filtered;
        end else if (wr_sel && !mism_hit) begin
            en_d = (en_q & lk_q) | (wdata & ~lk_q);
        end
    end

    // State registers: enable word and set-only lock word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
            lk_q <= '0;
        end else begin
            en_q <= en_d;
            if (lk_sel) begin
                lk_q <= lk_q | wdata;
            end
        end
    end
endmodule

// File: rtl/dpb_rdmux.sv
// Read-data selector over the four register windows.
// Assumes: region and idx come from dpb_decode, and unmapped reads return zero.
module dpb_rdmux
    import dpb_pkg::*;
#(
    parameter int NW = 4,
    parameter int DW = 32
) (
    input  dpb_region_e           region,
    input  logic [$clog2(NW)-1:0] idx,
    input  logic [NW*DW-1:0]      en_all,
    input  logic [NW*DW-1:0]      lk_all,
    input  logic [NW*DW-1:0]      spm_all,
    input  logic [NW*DW-1:0]      dm_all,
    output logic [DW-1:0]         rd_data
);
    // Pick the addressed word from the addressed window.
    always_comb begin
        case (region)
            RG_EN:   rd_data = en_all[idx*DW +: DW];
            RG_LOCK: rd_data = lk_all[idx*DW +: DW];
            RG_SPM:  rd_data = spm_all[idx*DW +: DW];
            RG_DM:   rd_data = dm_all[idx*DW +: DW];
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/dbg_pair_bank.sv
// Debug enable bank: NW words of parity-paired (or plain) enable bits, with locks and masks.
// Assumes: single-cycle register port, and masks supplied as inputs that stay stable.
module dbg_pair_bank
    import dpb_pkg::*;
#(
    parameter int AW     = 12,
    parameter int NW     = 4,
    parameter int DW     = 32,
    parameter bit PARITY = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_wr,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic [DW-1:0]    rd_data,
    input  logic             apply_sp_mask,
    input  logic [NW*DW-1:0] sp_dis_mask_i,
    input  logic [NW*DW-1:0] dis_mask_i,
    output logic [NW*DW-1:0] dbg_enable_o,
    output logic             mism_flag_o,
    output logic             lock_flag_o
);
    localparam int IW = $clog2(NW);

    dpb_region_e     region;
    logic [IW-1:0]   idx;
    logic [NW*DW-1:0] lock_all;
    logic [NW-1:0]   mism_v;
    logic [NW-1:0]   lock_v;
    logic            mism_q;
    logic            lockv_q;

    dpb_decode #(.AW(AW), .NW(NW), .BASE('h100)) u_dec (
        .addr   (req_addr),
        .region (region),
        .idx    (idx)
    );

    for (genvar g = 0; g < NW; g++) begin : g_word
        logic wsel;
        logic lsel;

        // Per-word write selects; the masking pulse suppresses enable writes.
        always_comb begin
            wsel = req_wr && !apply_sp_mask && region == RG_EN && idx == IW'(g);
            lsel = req_wr && region == RG_LOCK && idx == IW'(g);
        end

        dpb_word #(.DW(DW), .PARITY(PARITY)) u_word (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_sel   (wsel),
            .lk_sel   (lsel),
            .apply    (apply_sp_mask),
            .wdata    (req_wdata),
            .spm      (sp_dis_mask_i[g*DW +: DW]),
            .dm       (dis_mask_i[g*DW +: DW]),
            .en_q     (dbg_enable_o[g*DW +: DW]),
            .lk_q     (lock_all[g*DW +: DW]),
            .mism_hit (mism_v[g]),
            .lock_hit (lock_v[g])
        );
    end

    dpb_rdmux #(.NW(NW), .DW(DW)) u_rd (
        .region  (region),
        .idx     (idx),
        .en_all  (dbg_enable_o),
        .lk_all  (lock_all),
        .spm_all (sp_dis_mask_i),
        .dm_all  (dis_mask_i),
        .rd_data (rd_data)
    );

    // Sticky error flags, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mism_q  <= 1'b0;
            lockv_q <= 1'b0;
        end else begin
            mism_q  <= mism_q  | (|mism_v);
            lockv_q <= lockv_q | (|lock_v);
        end
    end

    assign mism_flag_o = mism_q;
    assign lock_flag_o = lockv_q;
endmodule

// File: rtl/dpb_chk.sv
// Property checker for dbg_pair_bank, attached with bind.
// Assumes: reset is held at time zero.
module dpb_chk #(
    parameter int NW     = 4,
    parameter int DW     = 32,
    parameter bit PARITY = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             apply_sp_mask,
    input logic [NW*DW-1:0] sp_dis_mask_i,
    input logic [NW*DW-1:0] dbg_enable_o,
    input logic [NW*DW-1:0] lock_all,
    input logic             mism_flag_o,
    input logic             lock_flag_o
);
    localparam logic [NW*DW-1:0] EN_ALL = PARITY ? {(NW*DW/2){2'b01}} : {(NW*DW){1'b1}};

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (dbg_enable_o == '0 && lock_all == '0 && !mism_flag_o && !lock_flag_o));

    // R4
    mism_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mism_flag_o |=> mism_flag_o);

    // R6
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_flag_o |=> lock_flag_o);

    // R5
    lock_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (($past(lock_all) & ~lock_all) == '0));

    // R6
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !apply_sp_mask |=> (((dbg_enable_o ^ $past(dbg_enable_o)) & $past(lock_all)) == '0));

    // R8
    apply_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        apply_sp_mask |=> ((dbg_enable_o & EN_ALL & ~$past(sp_dis_mask_i)) == '0));
endmodule

bind dbg_pair_bank dpb_chk #(.NW(NW), .DW(DW), .PARITY(PARITY)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .apply_sp_mask (apply_sp_mask),
    .sp_dis_mask_i (sp_dis_mask_i),
    .dbg_enable_o  (dbg_enable_o),
    .lock_all      (lock_all),
    .mism_flag_o   (mism_flag_o),
    .lock_flag_o   (lock_flag_o)
);

// File: tb/sim_dbg_pair_bank.sv
// Bench: a parity build (u0) and a plain build (u1) driven by the same stimulus.
// Each output is compared with an arithmetic model.
module sim_dbg_pair_bank;
    localparam int NW = 4;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n;
    logic req_wr;
    logic [11:0] req_addr;
    logic [31:0] req_wdata;
    logic apply_sp_mask;
    logic [127:0] spm;
    logic [127:0] dm;
    logic [31:0] rd0, rd1;
    logic [127:0] en0, en1;
    logic mf0, lf0, mf1, lf1;

    int checks = 0;
    int errors = 0;

    logic [31:0] e0 [NW];
    logic [31:0] e1 [NW];
    logic [31:0] lk [NW];
    logic xm0, xl0, xm1, xl1;

    always #2.5 clk = ~clk;

    dbg_pair_bank #(.PARITY(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_addr(req_addr),
        .req_wdata(req_wdata), .rd_data(rd0), .apply_sp_mask(apply_sp_mask),
        .sp_dis_mask_i(spm), .dis_mask_i(dm), .dbg_enable_o(en0),
        .mism_flag_o(mf0), .lock_flag_o(lf0)
    );

    dbg_pair_bank #(.PARITY(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_addr(req_addr),
        .req_wdata(req_wdata), .rd_data(rd1), .apply_sp_mask(apply_sp_mask),
        .sp_dis_mask_i(spm), .dis_mask_i(dm), .dbg_enable_o(en1),
        .mism_flag_o(mf1), .lock_flag_o(lf1)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Model of the provisioning filter, computed pair by pair.
    function automatic logic [31:0] m_apply(input logic [31:0] e, input logic [31:0] m, input bit par);
        logic [31:0] r;
        r = '0;
        if (par) begin
            for (int k = 0; k < 16; k++) begin
                r[2*k]   = e[2*k] & m[2*k];
                r[2*k+1] = !r[2*k] & m[2*k+1];
            end
        end else begin
            r = e & m;
        end
        return r;
    endfunction

    // Write model for one enable word: screen, flag, merge around the locks.
    task automatic m_write(inout logic [31:0] e, input logic [31:0] w, input logic [31:0] d,
                           input logic [31:0] l, inout logic mflag, inout logic lflag);
        if ((w & ~d) != 0) begin
            mflag = 1'b1;
        end else begin
            if (((w ^ e) & l) != 0) lflag = 1'b1;
            e = (e & l) | (w & ~l);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] w);
        int i;
        @(negedge clk);
        req_wr = 1'b1; req_addr = a; req_wdata = w;
        @(negedge clk);
        req_wr = 1'b0;
        if (a >= 12'h100 && a < 12'h110) begin
            i = int'((a - 12'h100) >> 2);
            m_write(e0[i], w, dm[i*32 +: 32], lk[i], xm0, xl0);
            m_write(e1[i], w, dm[i*32 +: 32], lk[i], xm1, xl1);
        end else if (a >= 12'h110 && a < 12'h120) begin
            i = int'((a - 12'h110) >> 2);
            lk[i] = lk[i] | w;
        end
    endtask

    task automatic pulse_apply(input bit with_wr, input logic [11:0] a, input logic [31:0] w);
        @(negedge clk);
        apply_sp_mask = 1'b1;
        if (with_wr) begin
            req_wr = 1'b1; req_addr = a; req_wdata = w;
        end
        @(negedge clk);
        apply_sp_mask = 1'b0; req_wr = 1'b0;
        for (int i = 0; i < NW; i++) begin
            e0[i] = m_apply(e0[i], spm[i*32 +: 32], 1'b1);
            e1[i] = m_apply(e1[i], spm[i*32 +: 32], 1'b0);
        end
        if (with_wr && a >= 12'h110 && a < 12'h120) begin
            lk[int'((a - 12'h110) >> 2)] |= w;
        end
    endtask

    task automatic rd(input logic [11:0] a);
        req_addr = a;
        #1;
    endtask

    // Compare every readable word, the output buses and the flags with the model.
    task automatic verify_all(input string req);
        for (int i = 0; i < NW; i++) begin
            rd(12'h100 + 12'(4*i));
            check({req, " en0"}, rd0, e0[i]);
            check({req, " en1"}, rd1, e1[i]);
            check({req, " out0"}, en0[i*32 +: 32], e0[i]);
            check({req, " out1"}, en1[i*32 +: 32], e1[i]);
            rd(12'h110 + 12'(4*i));
            check({req, " lock"}, rd0, lk[i]);
        end
        check({req, " mflag0"}, 32'(mf0), 32'(xm0));
        check({req, " lflag0"}, 32'(lf0), 32'(xl0));
        check({req, " mflag1"}, 32'(mf1), 32'(xm1));
        check({req, " lflag1"}, 32'(lf1), 32'(xl1));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] pats [8];
        pats[0] = 32'h00000000; pats[1] = 32'hFFFFFFFF; pats[2] = 32'h55555555;
        pats[3] = 32'hAAAAAAAA; pats[4] = 32'h33333333; pats[5] = 32'hC3C3A5A5;
        pats[6] = 32'h12345678; pats[7] = 32'hFEDCBA98;
        rst_n = 1'b0; req_wr = 1'b0; req_addr = '0; req_wdata = '0; apply_sp_mask = 1'b0;
        dm  = {32'h5555AAAA, 32'h00000000, 32'h0F0F0F0F, 32'hFFFFFFFF};
        spm = {32'hFFFFFFFF, 32'hA5A5A5A5, 32'h0000FFFF, 32'h9999CCCC};
        for (int i = 0; i < NW; i++) begin e0[i] = '0; e1[i] = '0; lk[i] = '0; end
        xm0 = 0; xl0 = 0; xm1 = 0; xl1 = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        verify_all("R1");

        // R2 R7: mask windows, unmapped and misaligned addresses
        for (int i = 0; i < NW; i++) begin
            bus_write(12'h120 + 12'(4*i), 32'hDEADBEEF);
            bus_write(12'h130 + 12'(4*i), 32'h00000000);
            rd(12'h120 + 12'(4*i)); check("R7 spm", rd0, spm[i*32 +: 32]);
            rd(12'h130 + 12'(4*i)); check("R7 dm", rd0, dm[i*32 +: 32]);
        end
        rd(12'h0FC); check("R2 below", rd0, 32'h0);
        rd(12'h140); check("R2 above", rd0, 32'h0);
        rd(12'h102); check("R2 misaligned", rd0, 32'h0);
        rd(12'h13C); check("R2 last", rd0, dm[96 +: 32]);

        // R3: walking one through word 0, plus a legal value for each word
        for (int b = 0; b < 32; b++) begin
            bus_write(12'h100, 32'h1 << b);
            rd(12'h100); check("R3 walk", rd0, 32'h1 << b);
        end
        bus_write(12'h104, 32'h05050A0A);
        bus_write(12'h10C, 32'h5050A0A0);
        verify_all("R3");

        // R4: refused writes leave the word and raise the flag
        bus_write(12'h104, 32'hFFFFFFFF);
        bus_write(12'h108, 32'h00000001);
        verify_all("R4");

        // R5 R6: set-only locks, then a write that hits locked bits
        bus_write(12'h100, 32'h0000003C);
        bus_write(12'h110, 32'h000000FF);
        bus_write(12'h110, 32'h00000000);
        bus_write(12'h100, 32'hAAAA5555);
        verify_all("R5 R6");

        // R10: apply beats a same-cycle enable write; a lock write still lands
        pulse_apply(1'b1, 12'h10C, 32'h00000000);
        verify_all("R10 drop");
        pulse_apply(1'b1, 12'h114, 32'h00F00000);
        verify_all("R10 lock");

        // R8 R9 R11: provisioning filter over a sweep of mask patterns
        for (int p = 0; p < 8; p++) begin
            spm = {pats[(p+3)%8], pats[(p+2)%8], pats[(p+1)%8], pats[p]};
            bus_write(12'h100, 32'hFFFFFFFF);
            bus_write(12'h104, 32'h0F0F0F0F);
            bus_write(12'h10C, 32'h5555AAAA);
            pulse_apply(1'b0, 12'h0, 32'h0);
            verify_all("R8 R9 R11");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule